// File: doc/BRIEF.md
# Directory Home Controller with Full Sharer Vector

This block is the home-side coherence controller of a directory-based MSI protocol. For every cache block it keeps a directory entry and the block's data in a small register file. Each entry holds a 2-bit stable or transient state, one sharer bit per cache, and a pointer to the current owner. Caches send it read requests (GetS), write requests (GetM) and eviction requests (PutS, PutM). It answers with data messages that carry the number of invalidation acknowledgements the requestor must collect. It can also forward a request to the owning cache, send invalidations to sharers, or acknowledge an eviction.

When a read hits a block that one cache holds modified, the home forwards the read to that owner. The block then enters a transient state until the owner's copy comes back on a separate write-back input. Further requests to that block are held off with `req_ready` until the copy arrives. A write to a block with several sharers produces one data message first. One invalidation per cycle follows, in ascending cache index, to every sharer other than the requestor. The request input is held off while these invalidations go out.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is invalid with no sharers and zero data. No message is valid, and `req_ready` is high.
- R2: A GetS (`req_type`=0) to an invalid or shared block sends a Data message (`msg_type`=0) to the requestor. The message carries the stored data and an ack count of 0. The block becomes shared, with the requestor added to its sharers.
- R3: A GetS to a modified block sends a forwarded read (`msg_type`=1) to the owner, with `msg_req` set to the requestor. Owner and requestor become the only sharers, and the block waits for the owner's data. A `wb_valid` cycle for that block stores `wb_data` and makes the block shared.
- R4: A GetM (`req_type`=1) to an invalid block sends Data with ack count 0 to the requestor. The requestor becomes the owner of a modified block.
- R5: A GetM to a shared block sends Data whose ack count is the number of sharers other than the requestor. In the following cycles, one invalidation (`msg_type`=3) goes out per cycle to each of those sharers in ascending index. The block becomes modified, owned by the requestor, with no sharers.
- R6: A GetM to a modified block sends a forwarded write (`msg_type`=2) to the current owner and makes the requestor the owner.
- R7: A PutM (`req_type`=3) from the owner of a modified block writes `req_data` to memory, sends a Put-Ack (`msg_type`=4) and makes the block invalid.
- R8: A PutM from any cache that is not the owner of a modified block is answered with a Put-Ack only. The block's entry and data are unchanged.
- R9: A PutS (`req_type`=2) sends a Put-Ack and removes the requestor from the sharers of a shared block. Once no sharer is left, a later GetM is answered with ack count 0 and no invalidations.
- R10: `req_ready` is low while invalidations are still pending, while `wb_valid` is high, and while the addressed block waits for owner data. Every message appears on the outputs the cycle after the request is accepted, and no message is valid in cycles without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_type | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_src | input | log2(NCACHE) | Requesting cache |
| req_addr | input | log2(NBLK) | Block index |
| req_data | input | DW | Data carried by PutM |
| wb_valid | input | 1 | Owner data returning for a block awaiting it |
| wb_addr | input | log2(NBLK) | Block of the returning data |
| wb_data | input | DW | Returning data |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 3 | 0 Data, 1 fwd read, 2 fwd write, 3 Inv, 4 Put-Ack |
| msg_dst | output | log2(NCACHE) | Destination cache |
| msg_req | output | log2(NCACHE) | Original requestor |
| msg_addr | output | log2(NBLK) | Block index |
| msg_ackcnt | output | log2(NCACHE+1) | Acks to collect (Data only, else 0) |
| msg_data | output | DW | Block data (Data only, else 0) |

## Verification
The assertions assume two things about the inputs. A cache never issues a GetS or GetM for a block it already owns in the modified state. A `wb_valid` pulse only arrives for a block that waits for owner data. Under these assumptions, invalidations never target the requestor and a modified block never keeps sharers. The stimulus, including the pseudo-random phase, swaps such owner requests for a PutM. It also issues the owner's data return right after each forwarded read, so a waiting block is always released.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {Q_GETS = 2'd0, Q_GETM = 2'd1, Q_PUTS = 2'd2, Q_PUTM = 2'd3} req_e;
  typedef enum logic [2:0] {M_DATA = 3'd0, M_FWDS = 3'd1, M_FWDM = 3'd2,
                            M_INV = 3'd3, M_PACK = 3'd4} msg_e;
  typedef enum logic [1:0] {B_I = 2'd0, B_S = 2'd1, B_M = 2'd2, B_SD = 2'd3} bst_e;
endpackage

// File: rtl/dir_store.sv
module dir_store import dir_pkg::*; #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 16,
  parameter int DW     = 8,
  localparam int CW = $clog2(NCACHE),
  localparam int AW = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ra_addr,
  output bst_e              ra_state,
  output logic [NCACHE-1:0] ra_sharers,
  output logic [CW-1:0]     ra_owner,
  output logic [DW-1:0]     ra_data,
  input  logic [AW-1:0]     rb_addr,
  output bst_e              rb_state,
  output logic [NCACHE-1:0] rb_sharers,
  output logic [CW-1:0]     rb_owner,
  input  logic              ent_we,
  input  logic [AW-1:0]     ent_waddr,
  input  bst_e              ent_wstate,
  input  logic [NCACHE-1:0] ent_wsharers,
  input  logic [CW-1:0]     ent_wowner,
  input  logic              dat_we,
  input  logic [AW-1:0]     dat_waddr,
  input  logic [DW-1:0]     dat_wdata
);
  bst_e              st_mem [NBLK];
  logic [NCACHE-1:0] sh_mem [NBLK];
  logic [CW-1:0]     ow_mem [NBLK];
  logic [DW-1:0]     dat_mem[NBLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) begin
        st_mem[i]  <= B_I;
        sh_mem[i]  <= '0;
        ow_mem[i]  <= '0;
        dat_mem[i] <= '0;
      end
    end else begin
      if (ent_we) begin
        st_mem[ent_waddr] <= ent_wstate;
        sh_mem[ent_waddr] <= ent_wsharers;
        ow_mem[ent_waddr] <= ent_wowner;
      end
      if (dat_we) dat_mem[dat_waddr] <= dat_wdata;
    end
  end

  assign ra_state   = st_mem[ra_addr];
  assign ra_sharers = sh_mem[ra_addr];
  assign ra_owner   = ow_mem[ra_addr];
  assign ra_data    = dat_mem[ra_addr];
  assign rb_state   = st_mem[rb_addr];
  assign rb_sharers = sh_mem[rb_addr];
  assign rb_owner   = ow_mem[rb_addr];

  // R4: a modified block is tracked by its owner pointer alone
  assert_m_no_sharers_R4: assert property (@(posedge clk) disable iff (rst)
    (ra_state == B_M) |-> (ra_sharers == '0));
  // R3: a block waiting for owner data always names the parties
  assert_sd_has_sharers_R3: assert property (@(posedge clk) disable iff (rst)
    (rb_state == B_SD) |-> (rb_sharers != '0));
endmodule

// File: rtl/inv_scan.sv
module inv_scan #(
  parameter int NCACHE = 4,
  localparam int CW = $clog2(NCACHE)
) (
  input  logic [NCACHE-1:0] vec,
  output logic [CW-1:0]     idx,
  output logic [NCACHE-1:0] pick
);
  always_comb begin
    idx = '0;
    for (int i = NCACHE - 1; i >= 0; i--) begin
      if (vec[i]) idx = CW'(i);
    end
  end
  assign pick = vec & (~vec + NCACHE'(1));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl import dir_pkg::*; #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 16,
  parameter int DW     = 8,
  localparam int CW = $clog2(NCACHE),
  localparam int AW = $clog2(NBLK),
  localparam int KW = $clog2(NCACHE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [CW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  output logic          msg_valid,
  output logic [2:0]    msg_type,
  output logic [CW-1:0] msg_dst,
  output logic [CW-1:0] msg_req,
  output logic [AW-1:0] msg_addr,
  output logic [KW-1:0] msg_ackcnt,
  output logic [DW-1:0] msg_data
);
  bst_e              st_a, st_b, wst;
  logic [NCACHE-1:0] sh_a, sh_b, wsh;
  logic [CW-1:0]     own_a, own_b, wown;
  logic [DW-1:0]     dat_a;
  logic              ent_we, dat_we;
  logic [AW-1:0]     ent_waddr, dat_waddr;
  logic [DW-1:0]     dat_wdata;

  logic [NCACHE-1:0] pend_q, pend_d, pick;
  logic [CW-1:0]     inv_req_q, inv_idx;
  logic [AW-1:0]     inv_addr_q;
  logic              fanout, accept, wb_hit;
  logic [NCACHE-1:0] src_bit, own_bit, others;
  logic [KW-1:0]     others_cnt;

  logic          m_v;
  msg_e          m_t;
  logic [CW-1:0] m_dst, m_req;
  logic [AW-1:0] m_addr;
  logic [KW-1:0] m_ack;
  logic [DW-1:0] m_dat;

  dir_store #(.NCACHE(NCACHE), .NBLK(NBLK), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .ra_addr(req_addr), .ra_state(st_a), .ra_sharers(sh_a), .ra_owner(own_a), .ra_data(dat_a),
    .rb_addr(wb_addr), .rb_state(st_b), .rb_sharers(sh_b), .rb_owner(own_b),
    .ent_we(ent_we), .ent_waddr(ent_waddr), .ent_wstate(wst), .ent_wsharers(wsh),
    .ent_wowner(wown), .dat_we(dat_we), .dat_waddr(dat_waddr), .dat_wdata(dat_wdata)
  );

  inv_scan #(.NCACHE(NCACHE)) u_scan (.vec(pend_q), .idx(inv_idx), .pick(pick));

  assign fanout    = |pend_q;
  assign req_ready = !fanout && !wb_valid && (st_a != B_SD);
  assign accept    = req_valid && req_ready;
  assign wb_hit    = wb_valid && (st_b == B_SD);
  assign src_bit   = NCACHE'(1) << req_src;
  assign own_bit   = NCACHE'(1) << own_a;
  assign others    = sh_a & ~src_bit;

  always_comb begin
    others_cnt = '0;
    for (int i = 0; i < NCACHE; i++) others_cnt = others_cnt + KW'(others[i]);
  end

  // directory entry and data updates
  always_comb begin
    ent_we    = 1'b0;
    ent_waddr = req_addr;
    wst       = st_a;
    wsh       = sh_a;
    wown      = own_a;
    dat_we    = 1'b0;
    dat_waddr = req_addr;
    dat_wdata = req_data;
    if (wb_hit) begin
      ent_we    = 1'b1;
      ent_waddr = wb_addr;
      wst       = B_S;
      wsh       = sh_b;
      wown      = own_b;
      dat_we    = 1'b1;
      dat_waddr = wb_addr;
      dat_wdata = wb_data;
    end else if (accept) begin
      unique case (req_e'(req_type))
        Q_GETS: begin
          ent_we = 1'b1;
          if (st_a == B_M) begin
            wst = B_SD;
            wsh = own_bit | src_bit;
          end else begin
            wst = B_S;
            wsh = sh_a | src_bit;
          end
        end
        Q_GETM: begin
          ent_we = 1'b1;
          wst    = B_M;
          wsh    = '0;
          wown   = req_src;
        end
        Q_PUTS: begin
          if (st_a == B_S) begin
            ent_we = 1'b1;
            wsh    = others;
            wst    = (others == '0) ? B_I : B_S;
          end
        end
        Q_PUTM: begin
          if (st_a == B_M && own_a == req_src) begin
            ent_we = 1'b1;
            dat_we = 1'b1;
            wst    = B_I;
            wown   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  // outgoing message selection
  always_comb begin
    m_v    = 1'b0;
    m_t    = M_PACK;
    m_dst  = req_src;
    m_req  = req_src;
    m_addr = req_addr;
    m_ack  = '0;
    m_dat  = '0;
    pend_d = pend_q;
    if (fanout) begin
      m_v    = 1'b1;
      m_t    = M_INV;
      m_dst  = inv_idx;
      m_req  = inv_req_q;
      m_addr = inv_addr_q;
      pend_d = pend_q & ~pick;
    end else if (accept) begin
      m_v = 1'b1;
      unique case (req_e'(req_type))
        Q_GETS: begin
          if (st_a == B_M) begin
            m_t   = M_FWDS;
            m_dst = own_a;
          end else begin
            m_t   = M_DATA;
            m_dat = dat_a;
          end
        end
        Q_GETM: begin
          if (st_a == B_M) begin
            m_t   = M_FWDM;
            m_dst = own_a;
          end else begin
            m_t   = M_DATA;
            m_dat = dat_a;
            if (st_a == B_S) begin
              m_ack  = others_cnt;
              pend_d = others;
            end
          end
        end
        default: m_t = M_PACK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      inv_req_q  <= '0;
      inv_addr_q <= '0;
      msg_valid  <= 1'b0;
      msg_type   <= '0;
      msg_dst    <= '0;
      msg_req    <= '0;
      msg_addr   <= '0;
      msg_ackcnt <= '0;
      msg_data   <= '0;
    end else begin
      pend_q    <= pend_d;
      if (accept) begin
        inv_req_q  <= req_src;
        inv_addr_q <= req_addr;
      end
      msg_valid  <= m_v;
      msg_type   <= m_t;
      msg_dst    <= m_dst;
      msg_req    <= m_req;
      msg_addr   <= m_addr;
      msg_ackcnt <= m_ack;
      msg_data   <= m_dat;
    end
  end

  // R5: invalidations never go back to the writer
  assert_inv_not_requestor_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == M_INV) |-> (msg_dst != msg_req));
  // R5: a Data message announcing acks is followed at once by an invalidation
  assert_inv_follows_data_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == M_DATA && msg_ackcnt != '0) |=>
      (msg_valid && msg_type == M_INV && msg_addr == $past(msg_addr)));
  // R5: ack count cannot exceed the number of other caches
  assert_ack_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == M_DATA) |-> (msg_ackcnt < KW'(NCACHE)));
  // R10: nothing is accepted while invalidations are still being issued
  assert_hold_in_fanout_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == M_INV && msg_ackcnt == '0 && $past(pend_q) != $past(pick))
      |-> !req_ready);
endmodule

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/1ps
module tb_dir_home_ctrl;
  localparam int NC = 4, NB = 16, DW = 8;
  localparam int CW = $clog2(NC), AW = $clog2(NB), KW = $clog2(NC + 1);
  localparam int SI = 0, SS = 1, SM = 2, SSD = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_type = 0;
  logic [CW-1:0] req_src = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic wb_valid = 0;
  logic [AW-1:0] wb_addr = 0;
  logic [DW-1:0] wb_data = 0;
  logic msg_valid;
  logic [2:0] msg_type;
  logic [CW-1:0] msg_dst, msg_req;
  logic [AW-1:0] msg_addr;
  logic [KW-1:0] msg_ackcnt;
  logic [DW-1:0] msg_data;

  dir_home_ctrl #(.NCACHE(NC), .NBLK(NB), .DW(DW)) dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {int typ; int dst; int rq; int addr; int data; int ack; string tag;} exp_t;
  exp_t exq[$];
  int st[NB], sh[NB], own[NB], mem[NB];
  int checks = 0, errors = 0;
  bit done = 0;
  int lfsr = 16'hACE1;

  task automatic push(int t, int d, int r, int a, int dat, int ack, string tag);
    exp_t e;
    e.typ = t; e.dst = d; e.rq = r; e.addr = a; e.data = dat; e.ack = ack; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic compare();
    checks++;
    if (exq.size() == 0) begin
      if (msg_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1/R10 idle: msg_valid=%0b expected 0", msg_valid);
      end
    end else begin
      exp_t e = exq.pop_front();
      if (msg_valid !== 1'b1 || int'(msg_type) != e.typ || int'(msg_dst) != e.dst ||
          int'(msg_req) != e.rq || int'(msg_addr) != e.addr || int'(msg_data) != e.data ||
          int'(msg_ackcnt) != e.ack) begin
        errors++;
        $display("FAIL %s: got v%0b t%0d d%0d r%0d a%0d data%0h ack%0d, expected v1 t%0d d%0d r%0d a%0d data%0h ack%0d",
                 e.tag, msg_valid, msg_type, msg_dst, msg_req, msg_addr, msg_data, msg_ackcnt,
                 e.typ, e.dst, e.rq, e.addr, e.data, e.ack);
      end
    end
  endtask

  task automatic model(int t, int s, int a, int d);
    if (t == 0) begin
      if (st[a] == SM) begin
        push(1, own[a], s, a, 0, 0, "R3 fwd read");
        sh[a] = (1 << own[a]) | (1 << s); st[a] = SSD;
      end else begin
        push(0, s, s, a, mem[a], 0, "R2 read data");
        sh[a] |= (1 << s); st[a] = SS;
      end
    end else if (t == 1) begin
      if (st[a] == SM) begin
        push(2, own[a], s, a, 0, 0, "R6 fwd write");
        own[a] = s;
      end else if (st[a] == SI) begin
        push(0, s, s, a, mem[a], 0, "R4 write data from I");
        own[a] = s; st[a] = SM; sh[a] = 0;
      end else begin
        int oth = sh[a] & ~(1 << s);
        push(0, s, s, a, mem[a], $countones(oth), "R5 write data with acks");
        for (int i = 0; i < NC; i++) if (oth[i]) push(3, i, s, a, 0, 0, "R5 invalidation");
        own[a] = s; st[a] = SM; sh[a] = 0;
      end
    end else if (t == 2) begin
      push(4, s, s, a, 0, 0, "R9 PutS ack");
      if (st[a] == SS) begin
        sh[a] &= ~(1 << s);
        if (sh[a] == 0) st[a] = SI;
      end
    end else begin
      if (st[a] == SM && own[a] == s) begin
        push(4, s, s, a, 0, 0, "R7 owner PutM ack");
        mem[a] = d; st[a] = SI; own[a] = 0;
      end else push(4, s, s, a, 0, 0, "R8 non-owner PutM ack");
    end
  endtask

  task automatic step(bit rv, int rt, int rs, int ra, int rd, bit wv, int wa, int wd, output bit acc);
    bit er;
    @(negedge clk);
    compare();
    req_valid = rv; req_type = 2'(rt); req_src = CW'(rs); req_addr = AW'(ra); req_data = DW'(rd);
    wb_valid = wv; wb_addr = AW'(wa); wb_data = DW'(wd);
    #1;
    er = (exq.size() == 0) && !wv && (st[ra] != SSD);
    if (rv) begin
      checks++;
      if (req_ready !== er) begin
        errors++;
        $display("FAIL R10 ready: got %0b expected %0b", req_ready, er);
      end
    end
    acc = rv && er;
    if (wv && st[wa] == SSD) begin mem[wa] = wd; st[wa] = SS; end
    if (acc) model(rt, rs, ra, rd);
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, a);
  endtask

  task automatic req(int t, int s, int a, int d);
    bit acc = 0;
    int tries = 0;
    while (!acc && tries < 40) begin
      step(1, t, s, a, d, 0, 0, 0, acc);
      tries++;
    end
    if (!acc) begin
      errors++; checks++;
      $display("FAIL R10 request never accepted: got stall expected accept");
    end
  endtask

  task automatic wb(int a, int d);
    bit x;
    step(0, 0, 0, 0, 0, 1, a, d, x);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < NB; i++) begin st[i] = SI; sh[i] = 0; own[i] = 0; mem[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    checks++;
    if (req_ready !== 1'b1 || msg_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got ready%0b valid%0b expected ready1 valid0", req_ready, msg_valid);
    end
    idle(2);
    req(0, 1, 5, 0);                       // R1 zero data, R2
    // R2 sharers build-up, R5 fan-out with stall attempt
    req(0, 0, 1, 0); req(0, 2, 1, 0); req(0, 3, 1, 0);
    req(1, 2, 1, 0);
    req(0, 1, 6, 0);                       // retried while invalidations drain (R10)
    req(3, 2, 1, 8'hA5);                   // R7
    req(0, 1, 1, 0);                       // R2 sees A5
    // R4, R6, R8, R3
    req(1, 0, 2, 0); req(1, 3, 2, 0);
    req(3, 0, 2, 8'h11);                   // R8 stale owner
    req(0, 1, 2, 0);                       // R3 forwarded to 3 proves R8 left it alone
    step(1, 0, 2, 2, 0, 0, 0, 0, a);       // R10 blocked on waiting block
    step(1, 0, 2, 2, 0, 0, 0, 0, a);
    step(1, 0, 2, 2, 0, 1, 2, 8'h3C, a);   // R3 owner data, R10 stall on wb
    req(0, 2, 2, 0);                       // R2 data 3C
    // R9
    req(3, 3, 4, 0);
    req(0, 1, 7, 0); req(0, 2, 7, 0); req(0, 3, 7, 0);
    req(2, 1, 7, 0);
    req(1, 0, 7, 0);                       // R5 acks 2 (cache 1 gone)
    req(0, 1, 9, 0); req(2, 1, 9, 0);
    req(1, 2, 9, 0);                       // R9 ack 0 after last left
    req(0, 1, 3, 0); req(0, 2, 3, 0);
    req(1, 1, 3, 0);                       // R5 requestor excluded
    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      int t, s, ad, d;
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      t = lfsr & 3; s = (lfsr >> 2) & 3; ad = 8 + ((lfsr >> 4) & 3); d = (lfsr >> 6) & 8'hFF;
      if (st[ad] == SM && own[ad] == s && t < 2) t = 3;
      req(t, s, ad, d);
      if (st[ad] == SSD) wb(ad, d ^ 8'h5A);
      if (((lfsr >> 14) & 1) == 1) idle(1);
    end
    idle(8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule